// File: doc/BRIEF.md
# SMBus Host Register Front-End

This block is the CPU-facing register file of an SMBus host controller. Software sees byte-wide registers for status, control, command, target address, two data bytes, a block byte and an auxiliary control byte. A write to control with the start bit set launches one transaction. The block then presents a request to a separate bus engine, waits for its completion, folds the result into the data registers and raises status flags. A level interrupt follows those flags.

If software starts a transaction with interrupts disabled, the block marks itself busy but holds the request back. The request is released by the next read of the status register. Software can abort a transaction at any time with the kill bit in the control register. Status flags are cleared by writing ones to them, except the busy flag, which only the hardware can change.

Top module: `smbh_host_regs`

## Requirements
- R1: After reset, status reads 0x00, control reads 0x00, `irq` is low and `req_valid` is low.
- R2: Offsets 0x03 (command), 0x04 (address), 0x05 (data0), 0x06 (data1) and 0x07 (block byte) read back what was written. Offset 0x0D keeps only bits 1:0. Any unmapped offset reads 0x00.
- R3: A status write clears every status bit written as 1, but bit 0 (busy) is never cleared by software.
- R4: A control read returns only bits 4:0 (bit 0 interrupt enable, bit 1 kill, bits 4:2 protocol). Start (bit 6) always reads 0.
- R5: A start with interrupt enable set raises `req_valid` on the write's clock edge. The request carries protocol = control[4:2], target = address[7:1], direction read = address[0], and the command, data0, data1 and block bytes. `req_valid` holds until `req_ready`, and status bit 0 (busy) stays set while the request is outstanding.
- R6: A completion without error clears busy and sets bit 1 (interrupt). A completion with `cpl_err` clears busy and sets bit 2 (device error).
- R7: On a successful completion, the block loads `cpl_data` into the data registers by protocol code:
  - codes 1 and 2, read: data0 takes the low byte.
  - code 3 read, or code 4 in either direction: data0 takes the low byte and data1 the high byte.
  - codes 5 and 6, read: data0 takes the low byte and the block byte takes the high byte.
  - code 0 and all writes leave the data registers unchanged, as does an error completion.
- R8: A start with protocol code 7 sets device error and issues no request.
- R9: While device error is set, a start issues no request and leaves status unchanged.
- R10: A start with interrupt enable clear sets busy and issues no request. The next status read returns the busy value, and the request appears on that read's clock edge.
- R11: A control write with bit 1 (kill) set drops any request, cancels a deferred start, clears busy and sets bit 4 (failed).
- R12: `irq` is high exactly when interrupt enable is set and any status bit other than busy is set.
- R13: When a completion and a status write arrive in the same cycle, the flags set by the completion survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read side effects) |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Level interrupt |
| req_valid | output | 1 | Transaction request to bus engine |
| req_ready | input | 1 | Bus engine accepts request |
| req_prot | output | 3 | Protocol code |
| req_target | output | 7 | 7-bit target address |
| req_read | output | 1 | Direction, 1 = read |
| req_cmd | output | 8 | Command byte |
| req_data0 | output | 8 | Data byte 0 |
| req_data1 | output | 8 | Data byte 1 |
| req_blk | output | 8 | Block byte |
| cpl_valid | input | 1 | Completion strobe |
| cpl_err | input | 1 | Completion failed |
| cpl_data | input | 16 | Returned data, low byte first |

## Verification
Two functions can act on the status register in one clock: a completion from the bus engine setting flags, and a software write-one-to-clear. The bench drives `cpl_valid` and a status write of the interrupt bit in the same cycle, then reads status. It expects the interrupt flag to still be set. A second overlap occurs on a deferred start: the status read clears busy and the released launch sets it again. The bench judges this by reading busy back, then seeing `req_valid` rise on that read's clock edge.

// File: rtl/smbh_pkg.sv
// Package: shared offsets, bit positions and encodings for the SMBus host register front-end.
// Assumes an 8-bit register data path and a 4-bit register offset.
package smbh_pkg;
    localparam int REG_AW = 4;
    localparam int REG_DW = 8;
    localparam int CPL_DW = 2 * REG_DW;

    localparam logic [REG_AW-1:0] OFS_STAT = 4'h0;
    localparam logic [REG_AW-1:0] OFS_CTL  = 4'h2;
    localparam logic [REG_AW-1:0] OFS_CMD  = 4'h3;
    localparam logic [REG_AW-1:0] OFS_ADDR = 4'h4;
    localparam logic [REG_AW-1:0] OFS_D0   = 4'h5;
    localparam logic [REG_AW-1:0] OFS_D1   = 4'h6;
    localparam logic [REG_AW-1:0] OFS_BLK  = 4'h7;
    localparam logic [REG_AW-1:0] OFS_AUX  = 4'hD;

    // status bit positions
    localparam int ST_BUSY   = 0;
    localparam int ST_INTR   = 1;
    localparam int ST_DEVERR = 2;
    localparam int ST_FAIL   = 4;

    // control bit positions
    localparam int CT_IEN   = 0;
    localparam int CT_KILL  = 1;
    localparam int CT_PLO   = 2;
    localparam int CT_PHI   = 4;
    localparam int CT_START = 6;
    localparam int CT_KEEP  = 5;   // bits kept in the control register
    localparam int AUX_KEEP = 2;   // bits kept in the auxiliary register

    typedef enum logic [2:0] {
        PR_QUICK, PR_BYTE, PR_BYTE_DATA, PR_WORD_DATA,
        PR_PROC_CALL, PR_BLOCK, PR_I2C_BLOCK, PR_RSVD
    } prot_e;

    typedef enum logic [1:0] {PH_IDLE, PH_REQ, PH_WAIT} phase_e;
endpackage

// File: rtl/smbh_status.sv
// Status register with software write-one-to-clear and hardware set/clear masks.
// Hardware set wins over any clear in the same cycle. Software can never clear busy.
module smbh_status
    import smbh_pkg::*;
#(
    parameter int W = REG_DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sw_clr,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] hw_clr,
    input  logic         ien,
    output logic [W-1:0] stat,
    output logic         irq
);
    localparam logic [W-1:0] BUSY_MASK = W'(1) << ST_BUSY;

    // Status update: clears first, then hardware sets.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~(sw_clr & ~BUSY_MASK) & ~hw_clr) | hw_set;
    end

    // Level interrupt from any non-busy flag when enabled.
    always_comb irq = ien && (|(stat & ~BUSY_MASK));

    AST_BUSY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stat[ST_BUSY] && sw_clr[ST_BUSY] && !hw_clr[ST_BUSY] |=> stat[ST_BUSY]); // R3
endmodule

// File: rtl/smbh_launch.sv
// Transaction sequencer: immediate or deferred launch, request handshake,
// completion, and kill. Produces status set/clear masks for smbh_status.
// Assumes only one completion per request and none while idle.
module smbh_launch
    import smbh_pkg::*;
#(
    parameter int W = REG_DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_wr,
    input  logic         kill_wr,
    input  logic         ien_wr,
    input  logic [2:0]   prot_wr,
    input  logic [2:0]   prot_cur,
    input  logic         stat_rd,
    input  logic         dev_err,
    input  logic         req_ready,
    input  logic         cpl_valid,
    input  logic         cpl_err,
    output logic         req_valid,
    output logic [W-1:0] hw_set,
    output logic [W-1:0] hw_clr,
    output logic         cpl_ok
);
    phase_e     ph, ph_n;
    logic       pend, pend_n, rv_n, go;
    logic [2:0] go_prot;

    // Next-state logic for phase, deferred flag, request and status masks.
    always_comb begin
        ph_n = ph; pend_n = pend; rv_n = req_valid;
        hw_set = '0; hw_clr = '0; cpl_ok = 1'b0;
        go = 1'b0; go_prot = prot_cur;
        if (kill_wr) begin
            ph_n = PH_IDLE; pend_n = 1'b0; rv_n = 1'b0;
            hw_set[ST_FAIL] = 1'b1; hw_clr[ST_BUSY] = 1'b1;
        end else begin
            if (ph == PH_REQ && req_ready) begin
                rv_n = 1'b0; ph_n = PH_WAIT;
            end
            if (ph == PH_WAIT && cpl_valid) begin
                ph_n = PH_IDLE; hw_clr[ST_BUSY] = 1'b1;
                if (cpl_err) hw_set[ST_DEVERR] = 1'b1;
                else begin hw_set[ST_INTR] = 1'b1; cpl_ok = 1'b1; end
            end
            if (ph == PH_IDLE && !pend) begin
                if (start_wr) begin
                    if (ien_wr) begin go = 1'b1; go_prot = prot_wr; end
                    else begin pend_n = 1'b1; hw_set[ST_BUSY] = 1'b1; end
                end
            end else if (ph == PH_IDLE && pend && stat_rd) begin
                pend_n = 1'b0; hw_clr[ST_BUSY] = 1'b1; go = 1'b1;
            end
            if (go && !dev_err) begin
                if (go_prot == 3'(PR_RSVD)) hw_set[ST_DEVERR] = 1'b1;
                else begin rv_n = 1'b1; ph_n = PH_REQ; hw_set[ST_BUSY] = 1'b1; end
            end
        end
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_IDLE; pend <= 1'b0; req_valid <= 1'b0;
        end else begin
            ph <= ph_n; pend <= pend_n; req_valid <= rv_n;
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready && !kill_wr |=> req_valid); // R5
    AST_DEVERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr && ien_wr && !kill_wr && dev_err && ph == PH_IDLE && !pend |=> !req_valid); // R9
    AST_KILL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        kill_wr |=> !req_valid && ph == PH_IDLE && !pend); // R11
endmodule

// File: rtl/smbh_host_regs.sv
// SMBus host register front-end: CPU register decode, data registers, readback,
// and the bus-side request/completion port. Assumes reg_wr and reg_rd are never
// high together and that the bus engine returns one completion per accepted request.
module smbh_host_regs
    import smbh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [2:0]        req_prot,
    output logic [6:0]        req_target,
    output logic              req_read,
    output logic [REG_DW-1:0] req_cmd,
    output logic [REG_DW-1:0] req_data0,
    output logic [REG_DW-1:0] req_data1,
    output logic [REG_DW-1:0] req_blk,
    input  logic              cpl_valid,
    input  logic              cpl_err,
    input  logic [CPL_DW-1:0] cpl_data
);
    logic [CT_KEEP-1:0]  ctl_q;
    logic [AUX_KEEP-1:0] aux_q;
    logic [REG_DW-1:0]   cmd_q, addr_q, d0_q, d1_q, blk_q, stat;
    logic [REG_DW-1:0]   sw_clr, hw_set, hw_clr;
    logic                wr_ctl, start_wr, kill_wr, stat_rd, cpl_ok;
    logic [2:0]          prot_cur;

    // Write decode and side-effect strobes.
    always_comb begin
        wr_ctl   = reg_wr && reg_addr == OFS_CTL;
        start_wr = wr_ctl && reg_wdata[CT_START];
        kill_wr  = wr_ctl && reg_wdata[CT_KILL];
        stat_rd  = reg_rd && reg_addr == OFS_STAT;
        sw_clr   = (reg_wr && reg_addr == OFS_STAT) ? reg_wdata : '0;
        prot_cur = ctl_q[CT_PHI:CT_PLO];
    end

    // Software-written registers and completion data loading (completion wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0; aux_q <= '0; cmd_q <= '0; addr_q <= '0;
            d0_q <= '0; d1_q <= '0; blk_q <= '0;
        end else begin
            if (wr_ctl) ctl_q <= reg_wdata[CT_KEEP-1:0];
            if (reg_wr) begin
                case (reg_addr)
                    OFS_CMD:  cmd_q  <= reg_wdata;
                    OFS_ADDR: addr_q <= reg_wdata;
                    OFS_D0:   d0_q   <= reg_wdata;
                    OFS_D1:   d1_q   <= reg_wdata;
                    OFS_BLK:  blk_q  <= reg_wdata;
                    OFS_AUX:  aux_q  <= reg_wdata[AUX_KEEP-1:0];
                    default: ;
                endcase
            end
            if (cpl_ok) begin
                case (prot_e'(prot_cur))
                    PR_BYTE, PR_BYTE_DATA:
                        if (addr_q[0]) d0_q <= cpl_data[REG_DW-1:0];
                    PR_WORD_DATA:
                        if (addr_q[0]) begin
                            d0_q <= cpl_data[REG_DW-1:0];
                            d1_q <= cpl_data[CPL_DW-1:REG_DW];
                        end
                    PR_PROC_CALL: begin
                        d0_q <= cpl_data[REG_DW-1:0];
                        d1_q <= cpl_data[CPL_DW-1:REG_DW];
                    end
                    PR_BLOCK, PR_I2C_BLOCK:
                        if (addr_q[0]) begin
                            d0_q  <= cpl_data[REG_DW-1:0];
                            blk_q <= cpl_data[CPL_DW-1:REG_DW];
                        end
                    default: ;
                endcase
            end
        end
    end

    // Readback multiplexer; unmapped offsets return zero.
    always_comb begin
        case (reg_addr)
            OFS_STAT: reg_rdata = stat;
            OFS_CTL:  reg_rdata = REG_DW'(ctl_q);
            OFS_CMD:  reg_rdata = cmd_q;
            OFS_ADDR: reg_rdata = addr_q;
            OFS_D0:   reg_rdata = d0_q;
            OFS_D1:   reg_rdata = d1_q;
            OFS_BLK:  reg_rdata = blk_q;
            OFS_AUX:  reg_rdata = REG_DW'(aux_q);
            default:  reg_rdata = '0;
        endcase
    end

    // Request fields come straight from the registers.
    always_comb begin
        req_prot   = prot_cur;
        req_target = addr_q[REG_DW-1:1];
        req_read   = addr_q[0];
        req_cmd    = cmd_q;
        req_data0  = d0_q;
        req_data1  = d1_q;
        req_blk    = blk_q;
    end

    smbh_launch #(.W(REG_DW)) u_launch (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .kill_wr(kill_wr),
        .ien_wr(reg_wdata[CT_IEN]), .prot_wr(reg_wdata[CT_PHI:CT_PLO]),
        .prot_cur(prot_cur), .stat_rd(stat_rd), .dev_err(stat[ST_DEVERR]),
        .req_ready(req_ready), .cpl_valid(cpl_valid), .cpl_err(cpl_err),
        .req_valid(req_valid), .hw_set(hw_set), .hw_clr(hw_clr), .cpl_ok(cpl_ok)
    );

    smbh_status #(.W(REG_DW)) u_status (
        .clk(clk), .rst_n(rst_n), .sw_clr(sw_clr), .hw_set(hw_set),
        .hw_clr(hw_clr), .ien(ctl_q[CT_IEN]), .stat(stat), .irq(irq)
    );

    AST_BUSY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> stat[ST_BUSY]); // R5
    AST_DEFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr && !kill_wr && !reg_wdata[CT_IEN] && !stat[ST_BUSY]
        |=> stat[ST_BUSY] && !req_valid); // R10
    AST_KILL_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        kill_wr |=> stat[ST_FAIL] && !stat[ST_BUSY]); // R11
endmodule

// File: tb/smbh_host_regs_bench.sv
// Bench: vector table of complete transactions walked by one loop, then directed tests.
module smbh_host_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0, reg_rdata;
    logic        irq, req_valid, req_ready = 1'b0, req_read;
    logic [2:0]  req_prot;
    logic [6:0]  req_target;
    logic [7:0]  req_cmd, req_data0, req_data1, req_blk;
    logic        cpl_valid = 1'b0, cpl_err = 1'b0;
    logic [15:0] cpl_data = '0;
    int errs = 0, checks = 0, cyc = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    smbh_host_regs u_smbh_host_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .req_valid(req_valid), .req_ready(req_ready),
        .req_prot(req_prot), .req_target(req_target), .req_read(req_read),
        .req_cmd(req_cmd), .req_data0(req_data0), .req_data1(req_data1),
        .req_blk(req_blk), .cpl_valid(cpl_valid), .cpl_err(cpl_err),
        .cpl_data(cpl_data)
    );

    typedef struct packed {
        logic [2:0]  prot;
        logic [7:0]  addr, cmd, d0, d1, blk;
        logic        err;
        logic [15:0] cdata;
        logic [7:0]  e_stat, e_d0, e_d1, e_blk;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 8'hA0, 8'h11, 8'h22, 8'h33, 8'h44, 1'b0, 16'hBEEF, 8'h02, 8'h22, 8'h33, 8'h44},
        '{3'd1, 8'hA1, 8'h12, 8'h22, 8'h33, 8'h44, 1'b0, 16'h005A, 8'h02, 8'h5A, 8'h33, 8'h44},
        '{3'd2, 8'hA0, 8'h13, 8'h66, 8'h33, 8'h44, 1'b0, 16'hFFFF, 8'h02, 8'h66, 8'h33, 8'h44},
        '{3'd3, 8'hA1, 8'h14, 8'h01, 8'h02, 8'h44, 1'b0, 16'h1234, 8'h02, 8'h34, 8'h12, 8'h44},
        '{3'd4, 8'hA0, 8'h15, 8'h01, 8'h02, 8'h44, 1'b0, 16'hABCD, 8'h02, 8'hCD, 8'hAB, 8'h44},
        '{3'd5, 8'hA1, 8'h16, 8'h01, 8'h02, 8'h44, 1'b0, 16'h9905, 8'h02, 8'h05, 8'h02, 8'h99},
        '{3'd3, 8'hA1, 8'h17, 8'h77, 8'h88, 8'h44, 1'b1, 16'h5555, 8'h04, 8'h77, 8'h88, 8'h44},
        '{3'd6, 8'hA1, 8'h18, 8'h01, 8'h02, 8'h44, 1'b0, 16'h7703, 8'h02, 8'h03, 8'h02, 8'h77}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            errs++; checks++;
            $display("FAIL watchdog: run hung act=%0d exp<20000", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        step();
        reg_rd = 1'b0;
    endtask

    task automatic accept();
        req_ready = 1'b1; step(); req_ready = 1'b0;
    endtask

    task automatic complete(input logic e, input logic [15:0] d);
        cpl_valid = 1'b1; cpl_err = e; cpl_data = d;
        step();
        cpl_valid = 1'b0; cpl_err = 1'b0;
    endtask

    initial begin
        logic [7:0] rv;
        vec_t v;
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        rd(4'h0, rv); chk("R1 status", rv, 8'h00);
        rd(4'h2, rv); chk("R1 control", rv, 8'h00);
        chk("R1 irq", irq, 1'b0);
        chk("R1 req_valid", req_valid, 1'b0);
        // R2 plain registers and unmapped offsets
        wr(4'h3, 8'h5C); rd(4'h3, rv); chk("R2 command", rv, 8'h5C);
        wr(4'h4, 8'hA7); rd(4'h4, rv); chk("R2 address", rv, 8'hA7);
        wr(4'hD, 8'hFF); rd(4'hD, rv); chk("R2 aux keeps bits 1:0", rv, 8'h03);
        wr(4'h1, 8'hFF); rd(4'h1, rv); chk("R2 unmapped 0x01", rv, 8'h00);
        wr(4'hF, 8'hFF); rd(4'hF, rv); chk("R2 unmapped 0x0F", rv, 8'h00);
        // R4 control readback masks bits 7:5
        wr(4'h2, 8'hBC); rd(4'h2, rv); chk("R4 control read", rv, 8'h1C);
        chk("R4 no start without bit 6", req_valid, 1'b0);
        wr(4'h2, 8'h00);

        // Table walk: complete transactions (R5, R6, R7, R12)
        for (int i = 0; i < 8; i++) begin
            v = VECS[i];
            wr(4'h3, v.cmd); wr(4'h4, v.addr); wr(4'h5, v.d0);
            wr(4'h6, v.d1);  wr(4'h7, v.blk);
            wr(4'h2, 8'h41 | {3'b000, v.prot, 2'b00});
            chk("R5 req_valid after start", req_valid, 1'b1);
            chk("R5 request fields",
                {req_prot, req_target, req_read, req_cmd, req_data0, req_data1, req_blk},
                {v.prot, v.addr[7:1], v.addr[0], v.cmd, v.d0, v.d1, v.blk});
            rd(4'h0, rv); chk("R5 busy while outstanding", rv, 8'h01);
            chk("R5 request held without ready", req_valid, 1'b1);
            accept();
            chk("R5 request drops after ready", req_valid, 1'b0);
            step(); step();
            complete(v.err, v.cdata);
            rd(4'h0, rv); chk("R6 status after completion", rv, v.e_stat);
            rd(4'h5, rv); chk("R7 data0", rv, v.e_d0);
            rd(4'h6, rv); chk("R7 data1", rv, v.e_d1);
            rd(4'h7, rv); chk("R7 block byte", rv, v.e_blk);
            chk("R12 irq with flag and enable", irq, 1'b1);
            wr(4'h0, 8'hFF);
            chk("R12 irq low after clear", irq, 1'b0);
        end

        // R8 reserved protocol
        wr(4'h2, 8'h5D);
        chk("R8 no request for code 7", req_valid, 1'b0);
        rd(4'h0, rv); chk("R8 device error", rv, 8'h04);
        // R9 start blocked while device error set
        wr(4'h2, 8'h45);
        chk("R9 no request", req_valid, 1'b0);
        step();
        chk("R9 still no request", req_valid, 1'b0);
        rd(4'h0, rv); chk("R9 status unchanged", rv, 8'h04);
        wr(4'h0, 8'hFF);

        // R10 deferred start with R3 busy stickiness (address still 0xA1: read)
        wr(4'h2, 8'h44);
        chk("R10 no request yet", req_valid, 1'b0);
        wr(4'h0, 8'hFF);
        rd(4'h0, rv); chk("R3 busy survives W1C / R10 read sees busy", rv, 8'h01);
        chk("R10 request released by status read", req_valid, 1'b1);
        accept(); step();
        complete(1'b0, 16'h0042);
        rd(4'h0, rv); chk("R10 status after deferred run", rv, 8'h02);
        chk("R12 irq low with enable clear", irq, 1'b0);
        rd(4'h5, rv); chk("R10 data0 loaded", rv, 8'h42);
        wr(4'h2, 8'h05);
        chk("R12 irq rises on enable", irq, 1'b1);
        wr(4'h0, 8'hFF);

        // R11 kill
        wr(4'h2, 8'h45);
        chk("R11 request up before kill", req_valid, 1'b1);
        wr(4'h2, 8'h02);
        chk("R11 request dropped", req_valid, 1'b0);
        rd(4'h0, rv); chk("R11 failed set, busy clear", rv, 8'h10);
        rd(4'h2, rv); chk("R4 kill bit readable", rv, 8'h02);
        wr(4'h2, 8'h00);
        wr(4'h0, 8'h10);
        rd(4'h0, rv); chk("R3 failed cleared by W1C", rv, 8'h00);
        // R11 kill cancels a deferred start
        wr(4'h2, 8'h44);
        wr(4'h2, 8'h02);
        rd(4'h0, rv); chk("R11 deferred cancelled", rv, 8'h10);
        chk("R11 no request after read", req_valid, 1'b0);
        wr(4'h2, 8'h00); wr(4'h0, 8'hFF);

        // R13 completion and status clear in the same cycle
        wr(4'h2, 8'h45);
        accept(); step();
        cpl_valid = 1'b1; cpl_data = 16'h0001;
        reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 8'h02;
        step();
        cpl_valid = 1'b0; reg_wr = 1'b0;
        rd(4'h0, rv); chk("R13 completion flag survives clear", rv, 8'h02);
        wr(4'h0, 8'hFF);
        rd(4'h0, rv); chk("R3 clear all", rv, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule